// File: doc/BRIEF.md
# Prioritised Interrupt Vectoring Unit

This block gathers five interrupt sources for a small CPU and presents a single request with the fixed vector address of the most urgent one. Two sources are external active-low pins, two are overflow flags coming from timers, and one is the combined transmit/receive flag of a serial port. Each external pin can be set to latch a falling edge into a flag or to be sensed while it is held low.

The CPU sees a request line and a 16-bit vector. It answers with a one-cycle acknowledge. The acknowledge clears the flag of a vectored external pin that is in edge mode, or sends a one-cycle clear pulse back to the timer that was vectored. Serial flags are never cleared by the unit. After an acknowledge the unit presents no request until the CPU signals a return from the service routine. A two-address register port holds the enables, the trigger modes and the readable edge flags.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, irq_req and tmr_clr are 0, and both registers read back as 0 (all sources disabled, both pins in level mode).
- R2: The source index is 0 for pin 0, 1 for timer 0, 2 for pin 1, 3 for timer 1 and 4 for serial. The vector issued for index i is 8*i+3, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R3: When several enabled sources are pending at once, the one with the lowest index is vectored.
- R4: A source can request only when its own enable bit (register 0, bit i) and the global enable (register 0, bit 7) are both 1.
- R5: In edge mode (register 1, bit p = 1), pin p passes through two synchroniser stages. A high sample followed by a low sample sets edge flag p, which reads as register 1 bit 2+p. The request then stays up after the pin goes high again.
- R6: In level mode (register 1, bit p = 0), pin p requests while its synchronised value is low. No flag is latched, and the request goes away once the pin is high.
- R7: Acknowledging a pin in edge mode clears its edge flag. Acknowledging timer t drives tmr_clr[t] high for exactly one cycle, and never more than one tmr_clr bit is high.
- R8: The serial request is the OR of ser_tx and ser_rx. An acknowledge does not clear it, so it requests again after the return.
- R9: In the cycle after an accepted acknowledge, irq_req is 0. It stays 0 until irq_ret is pulsed.
- R10: Writes go to the register selected by reg_addr. Register 1 bits 3:2 are read-only. reg_rdata shows the selected register one cycle after reg_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enables, 1 trigger modes and flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ext_pin_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_ovf | input | 2 | Timer overflow flags |
| tmr_clr | output | 2 | One-cycle clear pulse to the vectored timer |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_ret | input | 1 | Return-from-interrupt pulse |

## Verification
The bench sweeps all 32 combinations of pending sources and all 32 enable masks. A priority encoder that scans in the wrong direction would pick the wrong vector, and an inverted or ignored enable would leave a request standing. It latches a short low pulse on a pin in edge mode and checks that the request outlives the pulse, which a design that only senses the level would lose. It then checks the flag clears on acknowledge, and that a flag which never cleared would request again after the return. It also checks that the timer clear pulse lasts a single cycle, that the serial request comes back after the return because it is not cleared, and that nothing is requested between the acknowledge and the return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int NPIN  = 2;
  localparam int IDX_W = 3;
  localparam int VEC_W = 16;
  localparam int GIE_BIT = 7;
  localparam logic [IDX_W-1:0] SER_IDX = 3'd4;

  // vector address of a source index: 8*i + 3
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] i);
    return {{(VEC_W-IDX_W-3){1'b0}}, i, 3'b011};
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_n,
  output logic [NPIN-1:0] low,
  output logic [NPIN-1:0] fall
);
  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_pin
      logic s1, s2, s3;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= 1'b1;
          s2 <= 1'b1;
          s3 <= 1'b1;
        end else begin
          s1 <= pin_n[p];
          s2 <= s1;
          s3 <= s2;
        end
      end
      assign low[p]  = ~s2;
      assign fall[p] = s3 & ~s2;
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC  = 5,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]  pend,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = |pend;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NPIN-1:0]  ext_pin_n,
  input  logic [NPIN-1:0]  tmr_ovf,
  output logic [NPIN-1:0]  tmr_clr,
  input  logic             ser_tx,
  input  logic             ser_rx,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_ret
);
  logic [NSRC-1:0]  en_q;
  logic             gie_q;
  logic [NPIN-1:0]  mode_q, flag_q;
  logic             busy_q, busy_n, req_q, take;
  logic [IDX_W-1:0] idx_q, win_idx;
  logic [VEC_W-1:0] vec_q;
  logic [NPIN-1:0]  tclr_q, pin_low, pin_fall;
  logic [7:0]       rdata_q;
  logic [NSRC-1:0]  pend, masked;
  logic             win_valid;

  irq_pin_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst(rst), .pin_n(ext_pin_n), .low(pin_low), .fall(pin_fall)
  );

  assign take = irq_ack & req_q;

  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_src
      localparam logic [IDX_W-1:0] EXT_I = IDX_W'(2 * p);
      localparam logic [IDX_W-1:0] TMR_I = IDX_W'(2 * p + 1);
      assign pend[2*p]   = mode_q[p] ? flag_q[p] : pin_low[p];
      assign pend[2*p+1] = tmr_ovf[p];
      always_ff @(posedge clk) begin
        if (rst) begin
          flag_q[p] <= 1'b0;
          tclr_q[p] <= 1'b0;
        end else begin
          if (!mode_q[p])                  flag_q[p] <= 1'b0;
          else if (pin_fall[p])            flag_q[p] <= 1'b1;
          else if (take && idx_q == EXT_I) flag_q[p] <= 1'b0;
          tclr_q[p] <= take && idx_q == TMR_I;
        end
      end
    end
  endgenerate

  assign pend[SER_IDX] = ser_tx | ser_rx;
  assign masked = pend & en_q & {NSRC{gie_q}};

  irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .pend(masked), .valid(win_valid), .idx(win_idx)
  );

  always_comb begin
    busy_n = busy_q;
    if (take)         busy_n = 1'b1;
    else if (irq_ret) busy_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      gie_q   <= 1'b0;
      mode_q  <= '0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we && !reg_addr) begin
        en_q  <= reg_wdata[NSRC-1:0];
        gie_q <= reg_wdata[GIE_BIT];
      end
      if (reg_we && reg_addr) mode_q <= reg_wdata[NPIN-1:0];
      busy_q <= busy_n;
      req_q  <= win_valid && !busy_n;
      if (!busy_n) begin
        idx_q <= win_idx;
        vec_q <= vec_of(win_idx);
      end
      if (reg_addr) rdata_q <= 8'({flag_q, mode_q});
      else          rdata_q <= {gie_q, 7'(en_q)};
    end
  end

  assign irq_req   = req_q;
  assign irq_vec   = vec_q;
  assign tmr_clr   = tclr_q;
  assign reg_rdata = rdata_q;

  // R9
  ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !irq_req);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !irq_ret) |=> !irq_req);
  // R2
  vec_shape_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec < VEC_W'(8 * NSRC)));
  // R7
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tmr_clr));
  // R7
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|tmr_clr) |=> !(|tmr_clr));
  // R6
  level_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q[0] |=> !flag_q[0]);
  // R4
  gie_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!gie_q && !busy_q) |=> !irq_req);
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] pin_n = 2'b11, tf = 0, tmr_clr;
  logic stx = 0, srx = 0, req, ack = 0, ret = 0;
  logic [15:0] vec;
  int total = 0, bad = 0, clr0 = 0, clr1 = 0;

  always #2 clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin_n(pin_n),
    .tmr_ovf(tf), .tmr_clr(tmr_clr), .ser_tx(stx), .ser_rx(srx),
    .irq_req(req), .irq_vec(vec), .irq_ack(ack), .irq_ret(ret)
  );

  always @(posedge clk) begin
    if (tmr_clr[0]) clr0++;
    if (tmr_clr[1]) clr1++;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); ret = 1; @(negedge clk); ret = 0;
  endtask

  // drive a pending mask in level mode
  task automatic drive(input logic [4:0] m);
    pin_n = {~m[2], ~m[0]}; tf = {m[3], m[1]}; srx = m[4]; stx = 0;
  endtask

  function automatic logic [15:0] exp_vec(input logic [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return 16'(8 * i + 3);
    return 16'h0;
  endfunction

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    chk("R1 req", req, 0);
    chk("R1 clr", tmr_clr, 0);
    rd(0, d); chk("R1 reg0", d, 0);
    rd(1, d); chk("R1 reg1", d, 0);

    // R4 global off with sources on
    wr(0, 8'h1F); drive(5'h1F); cyc(6);
    chk("R4 gie off", req, 0);
    // R10 readback
    wr(0, 8'h9F); rd(0, d); chk("R10 reg0", d, 8'h9F);

    // R2 R3 sweep of pending masks
    for (int m = 0; m < 32; m++) begin
      drive(5'(m)); cyc(6);
      chk("R3 req", req, m != 0);
      if (m != 0) chk("R2 R3 vec", vec, exp_vec(5'(m)));
    end
    // R4 sweep of enable masks
    drive(5'h1F);
    for (int e = 0; e < 32; e++) begin
      wr(0, 8'h80 | 8'(e)); cyc(6);
      chk("R4 req", req, e != 0);
      if (e != 0) chk("R4 vec", vec, exp_vec(5'(e)));
    end
    drive(5'h00); wr(0, 8'h9F); cyc(6);
    chk("R6 idle", req, 0);

    // R5 edge mode on both pins, flags read-only
    wr(1, 8'h0F); rd(1, d); chk("R10 ro flags", d, 8'h03);
    @(negedge clk); pin_n[0] = 0; cyc(1); pin_n[0] = 1; cyc(6);
    chk("R5 req", req, 1); chk("R5 vec", vec, 16'h0003);
    rd(1, d); chk("R5 flag", d, 8'h07);
    // R7 R9 ack clears flag, quiet until return
    pulse_ack(); chk("R9 after ack", req, 0);
    rd(1, d); chk("R7 flag clr", d, 8'h03);
    cyc(4); chk("R9 busy", req, 0);
    pulse_ret(); cyc(3); chk("R7 no reissue", req, 0);

    // R7 timer clear pulse
    @(negedge clk); tf[1] = 1; cyc(4);
    chk("R7 t1 vec", vec, 16'h001B);
    pulse_ack(); chk("R7 clr pulse", tmr_clr, 2'b10);
    cyc(1); chk("R7 clr once", clr1, 1); chk("R7 clr0", clr0, 0);
    tf[1] = 0; pulse_ret(); cyc(3); chk("R7 t1 gone", req, 0);

    // R8 serial not cleared
    @(negedge clk); stx = 1; cyc(4);
    chk("R8 vec", vec, 16'h0023);
    pulse_ack(); cyc(4); chk("R8 busy", req, 0);
    pulse_ret(); cyc(3);
    chk("R8 again", req, 1); chk("R8 again vec", vec, 16'h0023);
    stx = 0; pulse_ack(); pulse_ret(); cyc(3);

    // R6 level mode on pin 1
    wr(1, 8'h00); @(negedge clk); pin_n[1] = 0; cyc(6);
    chk("R6 req", req, 1); chk("R6 vec", vec, 16'h0013);
    rd(1, d); chk("R6 no flag", d, 8'h00);
    pin_n[1] = 1; cyc(6); chk("R6 release", req, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule